// File: doc/BRIEF.md
# PWM Phase Count Detector

This block finds out at power-up how many of four PWM phases a multiphase controller should run. The phase count comes from the board strapping of the PWM output pins and not from a configuration register. When the soft-start sequencer signals the start of detection, a six-cycle window opens. During the window the pull-down sinks on the second, third and fourth PWM pins are switched on, the first PWM pin is held low, and in the last cycle of the window the comparator reading of each pin is latched. A pin that reads high has been strapped to the supply and is treated as unused.

After the window all sinks are released. Unused pins are put into high impedance, and the block produces one clock enable per active phase. The enables rotate through the active phases, one master-clock cycle apart, so each phase runs at the master clock divided by the phase count. A strapping that does not follow the expected pattern is mapped to the nearest lower valid count and raises an error flag. The result stays latched until the enable input drops or reset is applied.

Top module: `phase_detect`

## Requirements
- R1: While reset is asserted, and afterwards until detection starts, sinkEn, hiZ, phaseEn, phaseCount, strapErr and detectDone are all zero and holdLow is one.
- R2: A startDetect pulse seen while en is high and the block is idle opens a window of exactly 6 cycles, starting one cycle after the pulse. During the window sinkEn is all ones, holdLow is one, phaseEn is zero and detectDone is zero.
- R3: pinHigh bit 0, bit 1 and bit 2 are the comparator readings of PWM2, PWM3 and PWM4, and they are latched in the last window cycle. The valid patterns decode as follows: none high gives count 4, PWM4 high gives 3, PWM3 and PWM4 high give 2, all three high give 1. A valid pattern leaves strapErr at zero.
- R4: Any other pattern sets strapErr. For such a pattern, phaseCount equals one plus the number of PWM pins below the lowest-numbered pin that reads high, counting from PWM2.
- R5: From the first cycle after the window, sinkEn is zero, detectDone is one, and hiZ bit g (the pin PWM g+2) is one exactly when g+1 is greater than or equal to phaseCount.
- R6: In the first cycle after the window, phaseEn is 0001, which enables PWM1. On each later cycle the single set bit moves to the next phase and wraps from phase phaseCount back to PWM1.
- R7: Once latched, phaseCount and strapErr do not change in response to later changes of pinHigh or to further startDetect pulses while en stays high.
- R8: A cycle with en low returns the block to the R1 state on the next clock edge. startDetect is ignored while en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Converter enable; low clears the detection result |
| startDetect | input | 1 | Start-of-soft-start strobe that opens the window |
| pinHigh | input | 3 | Comparator readings of PWM2..PWM4 (bit 0 = PWM2) |
| sinkEn | output | 3 | Pull-down sink enables for PWM2..PWM4 |
| hiZ | output | 3 | Tristate controls for PWM2..PWM4 |
| holdLow | output | 1 | Forces PWM1 low while not running |
| phaseEn | output | 4 | One-hot rotating phase clock enables (bit 0 = PWM1) |
| phaseCount | output | 3 | Latched active phase count, 0 before detection |
| strapErr | output | 1 | Strapping did not match a valid pattern |
| detectDone | output | 1 | Detection finished and phases are running |

## Verification
The strap decode is driven with all four valid patterns. These separate the counts 1 to 4, and each count then shows its own hiZ mask and its own wrap point in the phase rotation. Three invalid patterns follow: PWM3 alone, PWM2 alone, and PWM2 with PWM4. They show that the count is set by the lowest high pin and that the error flag is raised, and not that the pins are simply counted. The inputs are also changed after latching, a start pulse is given while en is low, and the window length is checked cycle by cycle. These cases tell a correctly timed sample point and a correct hold apart from a decoder that follows its inputs continuously.

// File: rtl/phdet_pkg.sv
package phdet_pkg;
  typedef struct packed {
    logic detecting;
    logic sampleNow;
    logic running;
    logic clearAll;
  } phStrobe_t;
endpackage

// File: rtl/phdet_ctrl.sv
module phdet_ctrl
  import phdet_pkg::*;
#(
  parameter int DET_CYCLES = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      en,
  input  logic      startDetect,
  output phStrobe_t strobe
);
  localparam int CW = $clog2(DET_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DET_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DETECT, ST_RUN} phState_t;

  phState_t state;
  logic [CW-1:0] winCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else if (!en) begin
      state  <= ST_IDLE;
      winCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          winCnt <= '0;
          if (startDetect) state <= ST_DETECT;
        end
        ST_DETECT: begin
          if (winCnt == LAST) begin
            state  <= ST_RUN;
            winCnt <= '0;
          end else begin
            winCnt <= winCnt + CW'(1);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.detecting = (state == ST_DETECT);
    strobe.sampleNow = (state == ST_DETECT) && (winCnt == LAST) && en;
    strobe.running   = (state == ST_RUN);
    strobe.clearAll  = !en;
  end
endmodule

// File: rtl/phdet_dp.sv
module phdet_dp
  import phdet_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  phStrobe_t                    strobe,
  input  logic [PHASES-2:0]            pinHigh,
  output logic [PHASES-2:0]            sinkEn,
  output logic [PHASES-2:0]            hiZ,
  output logic [PHASES-1:0]            phaseEn,
  output logic [$clog2(PHASES+1)-1:0]  phaseCount,
  output logic                         strapErr
);
  localparam int SW = PHASES - 1;
  localparam int NW = $clog2(PHASES + 1);
  localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

  logic [NW-1:0] decCount;
  logic          decErr;
  logic [NW-1:0] cntQ;
  logic          errQ;
  logic [PW-1:0] ptr;

  // Lowest high pin sets the count; a high pin followed by a low one is an error.
  always_comb begin
    decCount = NW'(PHASES);
    for (int i = SW - 1; i >= 0; i--) begin
      if (pinHigh[i]) decCount = NW'(i + 1);
    end
    decErr = 1'b0;
    for (int i = 0; i < SW - 1; i++) begin
      if (pinHigh[i] && !pinHigh[i+1]) decErr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      errQ <= 1'b0;
      ptr  <= '0;
    end else if (strobe.clearAll) begin
      cntQ <= '0;
      errQ <= 1'b0;
      ptr  <= '0;
    end else begin
      if (strobe.sampleNow) begin
        cntQ <= decCount;
        errQ <= decErr;
      end
      if (strobe.running) begin
        if (NW'(ptr) >= cntQ - NW'(1)) ptr <= '0;
        else                           ptr <= ptr + PW'(1);
      end else begin
        ptr <= '0;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < PHASES; g++) begin : gPhase
      assign phaseEn[g] = strobe.running && (ptr == PW'(g));
    end
    for (g = 0; g < SW; g++) begin : gPin
      assign sinkEn[g] = strobe.detecting;
      assign hiZ[g]    = strobe.running && (NW'(g + 1) >= cntQ);
    end
  endgenerate

  assign phaseCount = cntQ;
  assign strapErr   = errQ;
endmodule

// File: rtl/phase_detect.sv
module phase_detect
  import phdet_pkg::*;
#(
  parameter int PHASES     = 4,
  parameter int DET_CYCLES = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         en,
  input  logic                         startDetect,
  input  logic [PHASES-2:0]            pinHigh,
  output logic [PHASES-2:0]            sinkEn,
  output logic [PHASES-2:0]            hiZ,
  output logic                         holdLow,
  output logic [PHASES-1:0]            phaseEn,
  output logic [$clog2(PHASES+1)-1:0]  phaseCount,
  output logic                         strapErr,
  output logic                         detectDone
);
  phStrobe_t strobe;

  phdet_ctrl #(.DET_CYCLES(DET_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .en          (en),
    .startDetect (startDetect),
    .strobe      (strobe)
  );

  phdet_dp #(.PHASES(PHASES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pinHigh    (pinHigh),
    .sinkEn     (sinkEn),
    .hiZ        (hiZ),
    .phaseEn    (phaseEn),
    .phaseCount (phaseCount),
    .strapErr   (strapErr)
  );

  assign holdLow    = !strobe.running;
  assign detectDone = strobe.running;
endmodule

// File: rtl/phase_detect_chk.sv
module phase_detect_chk #(
  parameter int PHASES     = 4,
  parameter int DET_CYCLES = 6
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         en,
  input logic [PHASES-2:0]            sinkEn,
  input logic [PHASES-2:0]            hiZ,
  input logic                         holdLow,
  input logic [PHASES-1:0]            phaseEn,
  input logic [$clog2(PHASES+1)-1:0]  phaseCount,
  input logic                         strapErr,
  input logic                         detectDone
);
  localparam int LW = $clog2(DET_CYCLES + 2);
  logic [LW-1:0] sinkRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sinkRun <= '0;
    else if (|sinkEn) sinkRun <= sinkRun + LW'(1);
    else              sinkRun <= '0;
  end

  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (|sinkEn) |-> (sinkRun < LW'(DET_CYCLES))); // R2

  AST_HOLD_NO_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    holdLow |-> (phaseEn == '0)); // R2

  AST_SINK_HIZ_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(|(sinkEn & hiZ))); // R5

  AST_DONE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detectDone) |-> $past(|sinkEn)); // R5

  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(phaseEn)); // R6

  AST_ROTATE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (detectDone && en && phaseEn[0] && (phaseCount > 1)) |=> phaseEn[1]); // R6

  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (detectDone && $past(detectDone)) |-> $stable(phaseCount)); // R7

  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strapErr |-> detectDone); // R4

  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (!detectDone && (phaseCount == '0))); // R8
endmodule

bind phase_detect phase_detect_chk #(.PHASES(PHASES), .DET_CYCLES(DET_CYCLES)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .en         (en),
  .sinkEn     (sinkEn),
  .hiZ        (hiZ),
  .holdLow    (holdLow),
  .phaseEn    (phaseEn),
  .phaseCount (phaseCount),
  .strapErr   (strapErr),
  .detectDone (detectDone)
);

// File: tb/sim_phase_detect.sv
`timescale 1ns/1ps
module sim_phase_detect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic       startDetect = 1'b0;
  logic [2:0] pinHigh = 3'b000;
  logic [2:0] sinkEn, hiZ;
  logic       holdLow, strapErr, detectDone;
  logic [3:0] phaseEn;
  logic [2:0] phaseCount;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  phase_detect u0 (
    .clk(clk), .rstN(rstN), .en(en), .startDetect(startDetect),
    .pinHigh(pinHigh), .sinkEn(sinkEn), .hiZ(hiZ), .holdLow(holdLow),
    .phaseEn(phaseEn), .phaseCount(phaseCount), .strapErr(strapErr),
    .detectDone(detectDone)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(req, "sinkEn", 32'(sinkEn), 0);
    chk(req, "hiZ", 32'(hiZ), 0);
    chk(req, "phaseEn", 32'(phaseEn), 0);
    chk(req, "phaseCount", 32'(phaseCount), 0);
    chk(req, "strapErr", 32'(strapErr), 0);
    chk(req, "detectDone", 32'(detectDone), 0);
    chk(req, "holdLow", 32'(holdLow), 1);
  endtask

  // Drop en for one cycle so the block is idle again (R8)
  task automatic rearm();
    @(negedge clk); en = 1'b0;
    @(negedge clk); checkIdle("R8");
    en = 1'b1;
    @(negedge clk);
  endtask

  // Full detection run, then the rotation check
  task automatic runDetect(input logic [2:0] strap, input int expCount, input bit expErr, input string req);
    logic [2:0] expHiZ;
    rearm();
    pinHigh = strap;
    startDetect = 1'b1;
    @(negedge clk);
    startDetect = 1'b0;
    for (int c = 0; c < 6; c++) begin
      chk("R2", "sinkEn in window", 32'(sinkEn), 3'b111);
      chk("R2", "holdLow in window", 32'(holdLow), 1);
      chk("R2", "phaseEn in window", 32'(phaseEn), 0);
      chk("R2", "detectDone in window", 32'(detectDone), 0);
      @(negedge clk);
    end
    expHiZ = '0;
    for (int g = 0; g < 3; g++) if (g + 1 >= expCount) expHiZ[g] = 1'b1;
    chk(req, "phaseCount", 32'(phaseCount), 32'(expCount));
    chk(req, "strapErr", 32'(strapErr), 32'(expErr));
    chk("R5", "sinkEn after", 32'(sinkEn), 0);
    chk("R5", "detectDone", 32'(detectDone), 1);
    chk("R5", "hiZ", 32'(hiZ), 32'(expHiZ));
    for (int k = 0; k < 2 * expCount + 1; k++) begin
      chk("R6", "phaseEn rotation", 32'(phaseEn), 32'(4'b0001 << (k % expCount)));
      @(negedge clk);
    end
  endtask

  task automatic testHold();
    runDetect(3'b100, 3, 1'b0, "R3");
    pinHigh = 3'b111;
    startDetect = 1'b1;
    @(negedge clk);
    startDetect = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7", "count after strap change", 32'(phaseCount), 3);
    chk("R7", "err after strap change", 32'(strapErr), 0);
    chk("R7", "no new window", 32'(sinkEn), 0);
    chk("R7", "still done", 32'(detectDone), 1);
  endtask

  task automatic testEnLowStart();
    @(negedge clk);
    en = 1'b0; pinHigh = 3'b000; startDetect = 1'b1;
    @(negedge clk);
    startDetect = 1'b0;
    chk("R8", "sinkEn with en low", 32'(sinkEn), 0);
    en = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8", "ignored start sinkEn", 32'(sinkEn), 0);
    chk("R8", "ignored start done", 32'(detectDone), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1");
    en = 1'b1;
    repeat (2) @(negedge clk);
    checkIdle("R1");
    runDetect(3'b000, 4, 1'b0, "R3");
    runDetect(3'b100, 3, 1'b0, "R3");
    runDetect(3'b110, 2, 1'b0, "R3");
    runDetect(3'b111, 1, 1'b0, "R3");
    runDetect(3'b010, 2, 1'b1, "R4");
    runDetect(3'b001, 1, 1'b1, "R4");
    runDetect(3'b101, 1, 1'b1, "R4");
    testHold();
    testEnLowStart();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule